// File: doc/BRIEF.md
# Sampling ADC Conversion Controller

This block sits on the host side of a 12-bit serial sampling converter and runs one complete conversion each time it is asked. A start request raises the convert-start line for a timed acquisition window. If the alternate input or mode is wanted, the block first inserts a short high-low pulse before that window. It then drops the line to begin the conversion and waits out the conversion time. After that it clocks the result out of the converter with 16 serial clock cycles, using clock polarity 0 and clock phase 0.

The captured word is presented on a 12-bit output with a one-clock valid strobe. All durations are given in nanoseconds or kilohertz together with the system clock frequency. The block converts each of them to a whole number of system clock cycles, always rounding up, so every minimum the converter needs is met. Between conversions the convert-start line stays low, so the converter powers itself down.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After reset and whenever no conversion is in progress, `cnv_o` and `sclk_o` are low, `valid_o` is low, and `result_o` reads 0 until the first result.
- R2: An accepted start raises `cnv_o`. The final high pulse before the conversion (the acquisition window) lasts at least ACQ_NS worth of clock cycles, which is 350 cycles at the defaults.
- R3: `alt_mode_i` is sampled together with an accepted start. When it is 1, `cnv_o` first goes high for SEL_NS, then low for SEL_NS, then high for the acquisition window, giving two rising edges per conversion. When it is 0, `cnv_o` has exactly one rising edge per conversion.
- R4: The falling edge of `cnv_o` that ends acquisition is followed by at least CONV_NS worth of cycles (925 at the defaults) before the first rising `sclk_o` edge. `cnv_o` stays low while `sclk_o` runs.
- R5: `sclk_o` idles low. Each high phase and each low phase between its rising edges lasts at least HALF_CYC cycles, where HALF_CYC is the system clock in kHz divided by twice SCLK_KHZ, rounded up (16 at the defaults).
- R6: Each conversion produces exactly 16 rising `sclk_o` edges.
- R7: `sdata_i` is sampled on each rising `sclk_o` edge. The first 12 samples form `result_o` MSB first, so the first sample goes to bit 11. The last four samples are discarded.
- R8: `valid_o` pulses high for exactly one clock per conversion. `result_o` changes only in that cycle and then holds its value.
- R9: `start_i` and `alt_mode_i` are ignored while a conversion is in progress. They cause no extra `cnv_o` edge and no extra result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one conversion (acted on when idle) |
| alt_mode_i | input | 1 | Select the alternate input or mode for this conversion |
| sdata_i | input | 1 | Serial data from the converter |
| cnv_o | output | 1 | Convert-start line to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| result_o | output | 12 | Last converted word |
| valid_o | output | 1 | One-clock strobe marking a new result |

## Verification
The main function is exercised with all-zero, all-one and alternating-bit words, with single-bit words at both ends of the range, and with a run of words generated by a feedback shift register. Each word is read on both the primary path and the alternate path. The converter model returns a different word for each path, so a wrong or missing mode pulse shows up as a wrong result. The model also drives ones in some conversions and zeros in others after the twelfth bit, which exposes any leak of the discarded bits. Some conversions get an extra start request with the opposite mode in the middle of the cycle; this separates a controller that ignores the request from one that restarts or changes its mode.

// File: rtl/adc_conv_pkg.sv
package adc_conv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SEL,
    ST_ACQ,
    ST_CONV,
    ST_XFER,
    ST_DONE
  } conv_state_e;

  // integer division rounded up
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int HALF_CYC = 16,
  parameter int NBITS    = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sclk,
  output logic rise_now,
  output logic last_fall
);

  localparam int HW = $clog2(HALF_CYC + 1);
  localparam int CW = $clog2(NBITS + 1);
  localparam logic [HW-1:0] HALF_RELOAD = HW'(HALF_CYC - 1);
  localparam logic [CW-1:0] LAST_IDX    = CW'(NBITS - 1);

  logic [HW-1:0] half_q;
  logic [CW-1:0] falls_q;
  logic          sclk_q;
  logic          edge_now;

  assign edge_now  = run && (half_q == '0);
  assign rise_now  = edge_now && !sclk_q;
  assign last_fall = edge_now && sclk_q && (falls_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      half_q  <= HALF_RELOAD;
      sclk_q  <= 1'b0;
      falls_q <= '0;
    end else if (edge_now) begin
      half_q <= HALF_RELOAD;
      sclk_q <= ~sclk_q;
      if (sclk_q) begin
        falls_q <= falls_q + 1'b1;
      end
    end else begin
      half_q <= half_q - 1'b1;
    end
  end

  assign sclk = sclk_q;

endmodule

// File: rtl/adc_rx_shift.sv
module adc_rx_shift #(
  parameter int NBITS = 16,
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             sdata,
  output logic [RES_W-1:0] word
);

  logic [NBITS-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
    end else if (shift_en) begin
      sh_q <= {sh_q[NBITS-2:0], sdata};
    end
  end

  generate
    if (NBITS > RES_W) begin : g_trim
      // earliest samples carry the result; trailing samples fall off the bottom
      assign word = sh_q[NBITS-1 -: RES_W];
    end else begin : g_exact
      assign word = sh_q[RES_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl #(
  parameter int CLK_MHZ   = 250,
  parameter int ACQ_NS    = 1400,
  parameter int CONV_NS   = 3700,
  parameter int SEL_NS    = 100,
  parameter int SCLK_KHZ  = 8000,
  parameter int XFER_BITS = 16,
  parameter int RES_W     = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             alt_mode_i,
  input  logic             sdata_i,
  output logic             cnv_o,
  output logic             sclk_o,
  output logic [RES_W-1:0] result_o,
  output logic             valid_o
);

  import adc_conv_pkg::*;

  localparam int ACQ_CYC  = ceil_div(ACQ_NS * CLK_MHZ, 1000);
  localparam int CONV_CYC = ceil_div(CONV_NS * CLK_MHZ, 1000);
  localparam int SEL_CYC  = ceil_div(SEL_NS * CLK_MHZ, 1000);
  localparam int HALF_CYC = ceil_div(CLK_MHZ * 1000, 2 * SCLK_KHZ);
  localparam int MAX_CYC  = max2(max2(ACQ_CYC, CONV_CYC), SEL_CYC);
  localparam int TW       = $clog2(MAX_CYC + 1);

  conv_state_e      state_q, state_d;
  logic             tmr_load, tmr_done;
  logic [TW-1:0]    tmr_val;
  logic             sck_run, sck_rise, sck_last, sck_line;
  logic [RES_W-1:0] rx_word;
  logic             cnv_q, valid_q;
  logic [RES_W-1:0] result_q;

  // next-state decode
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = alt_mode_i ? ST_PRE : ST_ACQ;
      ST_PRE:  if (tmr_done) state_d = ST_SEL;
      ST_SEL:  if (tmr_done) state_d = ST_ACQ;
      ST_ACQ:  if (tmr_done) state_d = ST_CONV;
      ST_CONV: if (tmr_done) state_d = ST_XFER;
      ST_XFER: if (sck_last) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // duration of the phase being entered, minus one
  always_comb begin
    unique case (state_d)
      ST_PRE, ST_SEL: tmr_val = TW'(SEL_CYC - 1);
      ST_ACQ:         tmr_val = TW'(ACQ_CYC - 1);
      ST_CONV:        tmr_val = TW'(CONV_CYC - 1);
      default:        tmr_val = '0;
    endcase
  end

  assign tmr_load = (state_d != state_q);
  assign sck_run  = (state_q == ST_XFER);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cnv_q    <= 1'b0;
      valid_q  <= 1'b0;
      result_q <= '0;
    end else begin
      state_q <= state_d;
      cnv_q   <= (state_d == ST_PRE) || (state_d == ST_ACQ);
      valid_q <= (state_q == ST_DONE);
      if (state_q == ST_DONE) begin
        result_q <= rx_word;
      end
    end
  end

  adc_phase_timer #(
    .W(TW)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_done)
  );

  adc_sclk_gen #(
    .HALF_CYC(HALF_CYC),
    .NBITS   (XFER_BITS)
  ) u_sclk (
    .clk      (clk),
    .rst      (rst),
    .run      (sck_run),
    .sclk     (sck_line),
    .rise_now (sck_rise),
    .last_fall(sck_last)
  );

  adc_rx_shift #(
    .NBITS(XFER_BITS),
    .RES_W(RES_W)
  ) u_rx (
    .clk     (clk),
    .rst     (rst),
    .shift_en(sck_rise),
    .sdata   (sdata_i),
    .word    (rx_word)
  );

  assign cnv_o    = cnv_q;
  assign sclk_o   = sck_line;
  assign result_o = result_q;
  assign valid_o  = valid_q;

endmodule

// File: rtl/adc_conv_ctrl_chk.sv
module adc_conv_ctrl_chk #(
  parameter int CLK_MHZ  = 250,
  parameter int ACQ_NS   = 1400,
  parameter int CONV_NS  = 3700,
  parameter int SEL_NS   = 100,
  parameter int SCLK_KHZ = 8000,
  parameter int RES_W    = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             cnv_o,
  input logic             sclk_o,
  input logic [RES_W-1:0] result_o,
  input logic             valid_o
);

  localparam int ACQ_CYC  = (ACQ_NS * CLK_MHZ + 999) / 1000;
  localparam int CONV_CYC = (CONV_NS * CLK_MHZ + 999) / 1000;
  localparam int SEL_CYC  = (SEL_NS * CLK_MHZ + 999) / 1000;
  localparam int HALF_CYC = (CLK_MHZ * 1000 + 2 * SCLK_KHZ - 1) / (2 * SCLK_KHZ);
  localparam int SAT      = 1 << 20;

  int cnv_lo, cnv_hi, last_hi, sck_hi, sck_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnv_lo  <= SAT;
      cnv_hi  <= 0;
      last_hi <= 0;
      sck_hi  <= 0;
      sck_lo  <= SAT;
    end else begin
      cnv_lo <= cnv_o ? 0 : ((cnv_lo < SAT) ? cnv_lo + 1 : SAT);
      if (cnv_o) begin
        cnv_hi <= (cnv_hi < SAT) ? cnv_hi + 1 : SAT;
      end else if (cnv_hi != 0) begin
        last_hi <= cnv_hi;
        cnv_hi  <= 0;
      end
      sck_hi <= sclk_o ? ((sck_hi < SAT) ? sck_hi + 1 : SAT) : 0;
      sck_lo <= sclk_o ? 0 : ((sck_lo < SAT) ? sck_lo + 1 : SAT);
    end
  end

  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (!cnv_o && !sclk_o));

  // R2
  acq_window_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(sclk_o) && cnv_lo > SAT / 2 - SAT / 2 + CONV_CYC - 1) |-> (last_hi >= ACQ_CYC));

  // R3
  sel_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cnv_o) |-> (cnv_lo >= SEL_CYC));

  // R4
  conv_wait_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk_o) |-> (cnv_lo >= CONV_CYC));

  // R4
  cnv_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    sclk_o |-> !cnv_o);

  // R5
  sclk_high_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk_o) |-> (sck_hi >= HALF_CYC));

  // R5
  sclk_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk_o) |-> (sck_lo >= HALF_CYC));

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(result_o) |-> valid_o);

endmodule

bind adc_conv_ctrl adc_conv_ctrl_chk #(
  .CLK_MHZ (CLK_MHZ),
  .ACQ_NS  (ACQ_NS),
  .CONV_NS (CONV_NS),
  .SEL_NS  (SEL_NS),
  .SCLK_KHZ(SCLK_KHZ),
  .RES_W   (RES_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cnv_o   (cnv_o),
  .sclk_o  (sclk_o),
  .result_o(result_o),
  .valid_o (valid_o)
);

// File: tb/adc_conv_ctrl_bench.sv
module adc_conv_ctrl_bench;

  localparam int ACQ_MIN  = (1400 * 250 + 999) / 1000;
  localparam int CONV_MIN = (3700 * 250 + 999) / 1000;
  localparam int HALF_MIN = (250 * 1000 + 16000 - 1) / 16000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        alt_mode = 1'b0;
  logic        sdata;
  logic        cnv, sclk, valid;
  logic [11:0] result;

  int checks = 0;
  int errs   = 0;
  int done_cnt = 0;

  always #2 clk = ~clk;

  adc_conv_ctrl u_adc_conv_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start),
    .alt_mode_i(alt_mode),
    .sdata_i   (sdata),
    .cnv_o     (cnv),
    .sclk_o    (sclk),
    .result_o  (result),
    .valid_o   (valid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // converter model: word chosen by number of convert-start rises, MSB first
  logic [11:0] v_pri = '0, v_alt = '0;
  logic        v_tail = 1'b0;
  logic [11:0] m_word = '0;
  int          m_idx = 12;
  int          m_rise = 0;
  logic        m_cnv = 1'b0, m_sclk = 1'b0;

  always @(cnv or sclk) begin
    if (cnv === 1'b1 && !m_cnv) m_rise++;
    if (cnv === 1'b0 && m_cnv) begin
      m_word = (m_rise >= 2) ? v_alt : v_pri;
      m_idx  = 0;
    end
    if (sclk === 1'b1 && !m_sclk) m_rise = 0;
    if (sclk === 1'b0 && m_sclk) m_idx++;
    m_cnv  = (cnv === 1'b1);
    m_sclk = (sclk === 1'b1);
  end

  assign sdata = (m_idx < 12) ? m_word[11 - m_idx] : v_tail;

  // scoreboard: {alt, word}
  logic [12:0] exp_q[$];

  // monitor
  logic p_cnv = 1'b0, p_sclk = 1'b0;
  int hi_run = 0, lo_run = 0, last_hi = 0, s_run = 0;
  int cnv_rises = 0, sck_rises = 0, acq_len = 0, conv_wait = 0, min_half = 1 << 20;

  always @(negedge clk) begin
    if (!rst) begin
      if (cnv && !p_cnv) begin cnv_rises++; hi_run = 1; end
      else if (cnv) hi_run++;
      else if (!cnv && p_cnv) begin last_hi = hi_run; lo_run = 1; end
      else lo_run++;

      if (sclk != p_sclk) begin
        if (sclk) begin
          sck_rises++;
          if (sck_rises == 1) begin acq_len = last_hi; conv_wait = lo_run; end
          else if (s_run < min_half) min_half = s_run;
        end else if (s_run < min_half) min_half = s_run;
        s_run = 1;
      end else s_run++;

      if (valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9", "unexpected result", 1, 0);
        end else begin
          logic [12:0] e;
          e = exp_q.pop_front();
          check(result == e[11:0], "R7", "result word", int'(result), int'(e[11:0]));
          check(cnv_rises == (e[12] ? 2 : 1), "R3", "cnv rises", cnv_rises, e[12] ? 2 : 1);
          check(sck_rises == 16, "R6", "sclk rises", sck_rises, 16);
          check(acq_len >= ACQ_MIN, "R2", "acquisition cycles", acq_len, ACQ_MIN);
          check(conv_wait >= CONV_MIN, "R4", "conversion wait", conv_wait, CONV_MIN);
          check(min_half >= HALF_MIN, "R5", "sclk half period", min_half, HALF_MIN);
        end
        cnv_rises = 0;
        sck_rises = 0;
        min_half  = 1 << 20;
        done_cnt++;
      end
      p_cnv  = cnv;
      p_sclk = sclk;
    end
  end

  // driver
  task automatic run_conv(input logic alt, input logic [11:0] a, input logic [11:0] b,
                          input logic tl, input bit poke);
    int target;
    target = done_cnt + 1;
    v_pri  = a;
    v_alt  = b;
    v_tail = tl;
    exp_q.push_back({alt, alt ? b : a});
    @(negedge clk);
    start    = 1'b1;
    alt_mode = alt;
    @(negedge clk);
    start    = 1'b0;
    alt_mode = 1'b0;
    if (poke) begin
      // R9: request with opposite mode in the middle of the cycle
      repeat (400) @(negedge clk);
      start    = 1'b1;
      alt_mode = !alt;
      @(negedge clk);
      start    = 1'b0;
      alt_mode = 1'b0;
    end
    while (done_cnt < target) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [11:0] lf;
    int bad;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(cnv == 1'b0, "R1", "cnv in reset", int'(cnv), 0);
    check(sclk == 1'b0, "R1", "sclk in reset", int'(sclk), 0);
    check(valid == 1'b0, "R1", "valid in reset", int'(valid), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(result == 12'h000, "R1", "result after reset", int'(result), 0);

    run_conv(1'b0, 12'h000, 12'hFFF, 1'b1, 1'b0);
    run_conv(1'b0, 12'hFFF, 12'h000, 1'b0, 1'b0);
    run_conv(1'b0, 12'hA5A, 12'h5A5, 1'b1, 1'b0);
    run_conv(1'b1, 12'h123, 12'h800, 1'b0, 1'b0);
    run_conv(1'b1, 12'hFFF, 12'h001, 1'b1, 1'b0);
    run_conv(1'b0, 12'h800, 12'h7FF, 1'b1, 1'b1);
    run_conv(1'b1, 12'h3C3, 12'hC3C, 1'b0, 1'b1);
    lf = 12'hACE;
    for (int i = 0; i < 5; i++) begin
      lf = {lf[10:0], lf[11] ^ lf[10] ^ lf[9] ^ lf[3]};
      run_conv(i[0], lf, ~lf, i[1], 1'b0);
    end

    // R8: result holds after the strobe
    check(result == ~lf || result == lf, "R8", "result held", int'(result), int'(lf));

    // R1 / R9: lines stay idle, no stray result
    bad = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (cnv || sclk || valid) bad++;
    end
    check(bad == 0, "R1", "idle cycles with activity", bad, 0);
    check(exp_q.size() == 0, "R9", "pending results", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule